// File: doc/BRIEF.md
# Endpoint Configuration Space Responder

This block holds the configuration register space of a single-function endpoint with a type-0 header. A host drives memory-mapped configuration reads and writes on a plain 32-bit register port. The block pulls the bus, device, function and dword register fields out of each address and compares them with its strapped location. It answers reads for its own location and treats every other location as empty. Identity fields are fixed by parameters. The command register, a write-one-to-clear status register and six base address registers can be programmed.

Each base address register, called a BAR here, is set up by parameter as unused, as a 32-bit memory window, or as the lower half of a 64-bit window. Software finds the window size by writing all ones to the BAR and reading it back. Once software has stored a base and set the memory-enable command bit, the block compares every memory address on a separate input against the stored windows. It raises a one-hot hit line that downstream logic uses to steer the transaction.

Top module: `cfgsp_responder`

## Requirements
- R1: After reset the command register reads 0, the status event bits 15:11 read 0, `mem_enable` is 0, no `bar_hit` bit is set and `cfg_rdata` is 0.
- R2: A configuration address carries the bus in bits 27:20, the device in bits 19:15, the function in bits 14:12 and the dword register index in bits 11:2. Bits 1:0 and 31:28 select nothing. The block responds only when the bus equals `strap_bus`, the device equals `strap_dev` and the function is 0.
- R3: A read from any other location returns 0xFFFFFFFF, so the vendor ID reads as 0xFFFF. A write to any other location changes no register.
- R4: Dword 0 reads {device ID, vendor ID}. Dword 2 reads {class code, revision}. Dword 3 reads 0, so the header type is 0x00 and bit 7 (multifunction) is clear. Dword 13 carries the capability pointer in bits 7:0. Writes to these dwords are ignored.
- R5: `cfg_rdata` takes the value of a read on the clock edge that samples the request, and it holds that value until the next read.
- R6: BARs occupy dwords 4 to 9. After all ones are written, a used lower BAR reads back ones in its decoded address bits, zeros below them and type flags in bits 3:0. Bit 0 is 0 for memory. Bits 2:1 are 00 for a 32-bit window and 10 for a 64-bit window. Bit 3 marks a prefetchable window. Clearing bits 3:0 of that read-back and taking the two's complement gives the window size.
- R7: An unused BAR always reads 0. A BAR that is the upper half of a 64-bit pair stores and returns all 32 written bits.
- R8: A used BAR of size 2^k stores only address bits 31:k. The bits below k read as zero apart from the flags, so any stored base is naturally aligned.
- R9: Only command bits 1 and 2 can be written. Bit 0 (I/O space) always reads 0. `mem_enable` follows command bit 1.
- R10: Status bits 15:11 are set by the matching `stat_evt` bits. They clear only when dword 1 is written with a 1 in that bit. A 0 leaves the bit unchanged, and a set event in the same cycle wins over a clear. Status bit 4 reads 1 when a capability list is present.
- R11: `bar_hit[n]` is raised only when `mem_enable` is 1, BAR n is a used lower BAR with a non-zero stored base (both halves counted for a 64-bit pair), `mem_addr[31:0]` masked by the window mask equals the stored base, and `mem_addr[63:32]` equals the upper half (or zero for a 32-bit window).
- R12: `bar_hit` is one-hot or zero. When windows overlap, the lowest-numbered matching BAR wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_bus | input | 8 | Bus number this endpoint answers on |
| strap_dev | input | 5 | Device number this endpoint answers on |
| cfg_req | input | 1 | Configuration access strobe, one cycle per access |
| cfg_we | input | 1 | 1 for a write, 0 for a read |
| cfg_addr | input | 32 | Configuration address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| stat_evt | input | 5 | Event pulses that set status bits 15:11 |
| mem_addr | input | 64 | Memory transaction address to match against the BARs |
| mem_enable | output | 1 | Memory space enable (command bit 1) |
| bar_hit | output | 6 | One-hot BAR match for `mem_addr` |

## Verification
The bench builds the block with BAR0 as a 4 KiB 32-bit window, BAR1 unused, BAR2/BAR3 as a 16 KiB prefetchable 64-bit pair, BAR4 as a 256-byte window and BAR5 unused. This set covers every flag encoding, the upper-half path and both unused cases in one build. Because BAR0 and BAR4 sizes nest, programming them to the same base creates overlap and exercises the lowest-index priority. The 64-bit pair makes the upper-half comparison and the non-zero test over both halves matter. Using a strapped location away from zero lets random foreign bus, device and function values probe the decode.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  localparam int NUM_BARS = 6;
  localparam int DW_IDX_W = 10;

  // Dword indices the responder decodes
  localparam logic [DW_IDX_W-1:0] DW_ID      = 10'd0;
  localparam logic [DW_IDX_W-1:0] DW_CMDSTS  = 10'd1;
  localparam logic [DW_IDX_W-1:0] DW_CLASS   = 10'd2;
  localparam logic [DW_IDX_W-1:0] DW_HDR     = 10'd3;
  localparam logic [DW_IDX_W-1:0] DW_BAR_LO  = 10'd4;
  localparam logic [DW_IDX_W-1:0] DW_BAR_HI  = 10'd9;
  localparam logic [DW_IDX_W-1:0] DW_CAPPTR  = 10'd13;

  typedef struct packed {
    logic [7:0]          bus;
    logic [4:0]          dev;
    logic [2:0]          fn;
    logic [DW_IDX_W-1:0] dw;
  } cfg_loc_t;

  function automatic cfg_loc_t split_cfg_addr(input logic [31:0] a);
    cfg_loc_t s;
    s.bus = a[27:20];
    s.dev = a[19:15];
    s.fn  = a[14:12];
    s.dw  = a[11:2];
    return s;
  endfunction

  // Ones in the decoded address bits of a 2^lg window
  function automatic logic [31:0] bar_mask(input int unsigned lg);
    logic [31:0] m;
    m = '1;
    m = m << lg;
    return m;
  endfunction

  // bit3 prefetchable, bits2:1 window type (10 = 64-bit), bit0 memory (0)
  function automatic logic [3:0] bar_flags(input logic is64, input logic pref);
    return {pref, is64, 1'b0, 1'b0};
  endfunction

  // Isolate the lowest set bit
  function automatic logic [NUM_BARS-1:0] lowest_one(input logic [NUM_BARS-1:0] v);
    return v & (~v + {{(NUM_BARS-1){1'b0}}, 1'b1});
  endfunction

endpackage

// File: rtl/cfgsp_addr_decode.sv
module cfgsp_addr_decode
  import cfgsp_pkg::*;
(
  input  logic [31:0]         cfg_addr,
  input  logic [7:0]          strap_bus,
  input  logic [4:0]          strap_dev,
  output logic                loc_match,
  output logic [DW_IDX_W-1:0] dw_idx
);
  cfg_loc_t loc;
  logic     unused_addr_bits;

  assign loc              = split_cfg_addr(cfg_addr);
  assign unused_addr_bits = ^{cfg_addr[31:28], cfg_addr[1:0]};
  assign loc_match        = (loc.bus == strap_bus) && (loc.dev == strap_dev) && (loc.fn == 3'd0);
  assign dw_idx           = loc.dw;
endmodule

// File: rtl/cfgsp_ctrl_regs.sv
module cfgsp_ctrl_regs #(
  parameter logic [15:0] CMD_WMASK = 16'h0006,
  parameter bit          HAS_CAP   = 1'b1,
  parameter int          EVT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  input  logic [EVT_W-1:0] evt,
  output logic [15:0]      cmd,
  output logic [15:0]      sts,
  output logic [EVT_W-1:0] sticky
);
  localparam int EVT_LSB = 16 - EVT_W;

  logic [EVT_W-1:0] clr;
  logic             unused_wdata;

  assign clr          = wr_en ? wdata[16+EVT_LSB +: EVT_W] : '0;
  assign unused_wdata = ^wdata[16+EVT_LSB-1:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd    <= '0;
      sticky <= '0;
    end else begin
      if (wr_en) cmd <= wdata[15:0] & CMD_WMASK & 16'hFFFE;
      sticky <= (sticky & ~clr) | evt;
    end
  end

  always_comb begin
    sts          = '0;
    sts[4]       = HAS_CAP;
    sts[15:EVT_LSB] = sticky;
  end
endmodule

// File: rtl/cfgsp_bar_bank.sv
module cfgsp_bar_bank
  import cfgsp_pkg::*;
#(
  parameter logic [8*NUM_BARS-1:0] BAR_LOG2 = '0,
  parameter logic [NUM_BARS-1:0]   BAR_IS64 = '0,
  parameter logic [NUM_BARS-1:0]   BAR_PREF = '0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [2:0]                      wr_idx,
  input  logic [31:0]                     wdata,
  input  logic                            mem_en,
  input  logic [63:0]                     mem_addr,
  output logic [NUM_BARS-1:0][31:0]       bar_rd,
  output logic [NUM_BARS-1:0]             raw_hit,
  output logic [NUM_BARS-1:0]             hit
);
  for (genvar n = 0; n < NUM_BARS; n++) begin : g_bar
    localparam int          LG    = int'(BAR_LOG2[n*8 +: 8]);
    localparam int          PREV  = (n == 0) ? 0 : n - 1;
    localparam int          NXT   = (n == NUM_BARS - 1) ? n : n + 1;
    localparam bit          UPPER = (n != 0) && BAR_IS64[PREV];
    localparam bit          USED  = (LG != 0) && !UPPER;
    localparam logic [31:0] MASK  = bar_mask(LG);
    localparam logic [3:0]  FLG   = bar_flags(BAR_IS64[n], BAR_PREF[n]);

    logic sel;
    assign sel = wr_en && (wr_idx == 3'(n));

    if (USED) begin : g_used
      logic [31:0] q;
      logic [31:0] hi_w;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (sel) q <= wdata & MASK;
      end
      assign bar_rd[n]  = q | {28'd0, FLG};
      assign hi_w       = BAR_IS64[n] ? bar_rd[NXT] : 32'd0;
      assign raw_hit[n] = mem_en && ((q != 32'd0) || (hi_w != 32'd0))
                          && ((mem_addr[31:0] & MASK) == q)
                          && (mem_addr[63:32] == hi_w);
    end else if (UPPER) begin : g_upper
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (sel) q <= wdata;
      end
      assign bar_rd[n]  = q;
      assign raw_hit[n] = 1'b0;
    end else begin : g_off
      assign bar_rd[n]  = '0;
      assign raw_hit[n] = 1'b0;
    end
  end

  assign hit = lowest_one(raw_hit);
endmodule

// File: rtl/cfgsp_responder.sv
module cfgsp_responder
  import cfgsp_pkg::*;
#(
  parameter logic [15:0]           VENDOR_ID  = 16'h1E5A,
  parameter logic [15:0]           DEVICE_ID  = 16'h0A17,
  parameter logic [7:0]            REVISION   = 8'h02,
  parameter logic [23:0]           CLASS_CODE = 24'h058000,
  parameter logic [7:0]            CAP_PTR    = 8'h40,
  parameter bit                    HAS_CAP    = 1'b1,
  parameter logic [15:0]           CMD_WMASK  = 16'h0006,
  parameter logic [8*NUM_BARS-1:0] BAR_LOG2   = {8'd0, 8'd8, 8'd0, 8'd14, 8'd0, 8'd12},
  parameter logic [NUM_BARS-1:0]   BAR_IS64   = 6'b000100,
  parameter logic [NUM_BARS-1:0]   BAR_PREF   = 6'b000100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          strap_bus,
  input  logic [4:0]          strap_dev,
  input  logic                cfg_req,
  input  logic                cfg_we,
  input  logic [31:0]         cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic [4:0]          stat_evt,
  input  logic [63:0]         mem_addr,
  output logic                mem_enable,
  output logic [NUM_BARS-1:0] bar_hit
);
  localparam int EVT_W = 5;

  logic                      loc_match;
  logic [DW_IDX_W-1:0]       dw_idx;
  logic                      own_wr;
  logic                      status_wr;
  logic                      bar_wr;
  logic                      bar_range;
  logic [2:0]                bar_idx;
  logic [15:0]               cmd_word;
  logic [15:0]               sts_word;
  logic [EVT_W-1:0]          sts_sticky;
  logic [NUM_BARS-1:0][31:0] bar_rd;
  logic [NUM_BARS-1:0]       bar_raw_hit;
  logic [31:0]               rd_word;

  cfgsp_addr_decode u_dec (
    .cfg_addr  (cfg_addr),
    .strap_bus (strap_bus),
    .strap_dev (strap_dev),
    .loc_match (loc_match),
    .dw_idx    (dw_idx)
  );

  assign own_wr    = cfg_req && cfg_we && loc_match;
  assign status_wr = own_wr && (dw_idx == DW_CMDSTS);
  assign bar_range = (dw_idx >= DW_BAR_LO) && (dw_idx <= DW_BAR_HI);
  assign bar_wr    = own_wr && bar_range;
  assign bar_idx   = dw_idx[2:0] - 3'd4;

  cfgsp_ctrl_regs #(
    .CMD_WMASK (CMD_WMASK),
    .HAS_CAP   (HAS_CAP),
    .EVT_W     (EVT_W)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (status_wr),
    .wdata  (cfg_wdata),
    .evt    (stat_evt),
    .cmd    (cmd_word),
    .sts    (sts_word),
    .sticky (sts_sticky)
  );

  assign mem_enable = cmd_word[1];

  cfgsp_bar_bank #(
    .BAR_LOG2 (BAR_LOG2),
    .BAR_IS64 (BAR_IS64),
    .BAR_PREF (BAR_PREF)
  ) u_bars (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bar_wr),
    .wr_idx   (bar_idx),
    .wdata    (cfg_wdata),
    .mem_en   (mem_enable),
    .mem_addr (mem_addr),
    .bar_rd   (bar_rd),
    .raw_hit  (bar_raw_hit),
    .hit      (bar_hit)
  );

  always_comb begin
    rd_word = 32'd0;
    if (!loc_match) begin
      rd_word = 32'hFFFF_FFFF;
    end else if (bar_range) begin
      rd_word = bar_rd[bar_idx];
    end else begin
      case (dw_idx)
        DW_ID:     rd_word = {DEVICE_ID, VENDOR_ID};
        DW_CMDSTS: rd_word = {sts_word, cmd_word};
        DW_CLASS:  rd_word = {CLASS_CODE, REVISION};
        DW_HDR:    rd_word = 32'd0;
        DW_CAPPTR: rd_word = {24'd0, CAP_PTR};
        default:   rd_word = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cfg_rdata <= '0;
    else if (cfg_req && !cfg_we) cfg_rdata <= rd_word;
  end
endmodule

// File: rtl/cfgsp_checker.sv
module cfgsp_checker #(
  parameter int NB = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_req,
  input logic          cfg_we,
  input logic [31:0]   cfg_addr,
  input logic [31:0]   cfg_rdata,
  input logic          loc_match,
  input logic          status_wr,
  input logic [4:0]    sts_sticky,
  input logic          mem_enable,
  input logic [NB-1:0] bar_hit
);
  AST_FOREIGN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_we && !loc_match) |=> (cfg_rdata == 32'hFFFF_FFFF)); // R3

  AST_IO_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_we && loc_match && (cfg_addr[11:2] == 10'd1)) |=> (cfg_rdata[0] == 1'b0)); // R9

  AST_STS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(sts_sticky) & ~sts_sticky)) |-> $past(status_wr)); // R10

  AST_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_enable |-> (bar_hit == '0)); // R11

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bar_hit)); // R12
endmodule

bind cfgsp_responder cfgsp_checker #(.NB(cfgsp_pkg::NUM_BARS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_req    (cfg_req),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_rdata  (cfg_rdata),
  .loc_match  (loc_match),
  .status_wr  (status_wr),
  .sts_sticky (sts_sticky),
  .mem_enable (mem_enable),
  .bar_hit    (bar_hit)
);

// File: tb/cfgsp_responder_test.sv
module cfgsp_responder_test;
  localparam logic [7:0]  MY_BUS = 8'h2C;
  localparam logic [4:0]  MY_DEV = 5'd9;
  localparam logic [15:0] VID    = 16'h1E5A;
  localparam logic [15:0] DID    = 16'h0A17;
  localparam logic [7:0]  REV    = 8'h02;
  localparam logic [23:0] CLS    = 24'h058000;
  localparam logic [7:0]  CAPP   = 8'h40;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_req = 0, cfg_we = 0;
  logic [31:0] cfg_addr = 0, cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [4:0]  stat_evt = 0;
  logic [63:0] mem_addr = 0;
  logic        mem_enable;
  logic [5:0]  bar_hit;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] bb [6];
  bit men_exp = 0;

  always #2.5 clk = ~clk;

  cfgsp_responder #(
    .VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION(REV), .CLASS_CODE(CLS),
    .CAP_PTR(CAPP), .HAS_CAP(1'b1), .CMD_WMASK(16'h0006),
    .BAR_LOG2({8'd0, 8'd8, 8'd0, 8'd14, 8'd0, 8'd12}),
    .BAR_IS64(6'b000100), .BAR_PREF(6'b000100)
  ) uut (
    .clk(clk), .rst_n(rst_n), .strap_bus(MY_BUS), .strap_dev(MY_DEV),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .stat_evt(stat_evt), .mem_addr(mem_addr),
    .mem_enable(mem_enable), .bar_hit(bar_hit)
  );

  // Bench view of the BAR set: window size as log2, 0 = no window of its own
  function automatic int win_lg(input int n);
    case (n)
      0: return 12;
      2: return 14;
      4: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] win_flags(input int n);
    return (n == 2) ? 4'b1100 : 4'b0000;
  endfunction

  function automatic logic [31:0] win_store(input int n, input logic [31:0] d);
    if (n == 3) return d;
    if (win_lg(n) == 0) return 32'd0;
    return d & ~((32'd1 << win_lg(n)) - 32'd1);
  endfunction

  function automatic logic [31:0] win_read(input int n);
    if (n == 3) return bb[3];
    if (win_lg(n) == 0) return 32'd0;
    return bb[n] | {28'd0, win_flags(n)};
  endfunction

  function automatic logic [5:0] ref_hit(input logic [63:0] a);
    if (!men_exp) return 6'd0;
    for (int n = 0; n < 6; n++) begin
      if (win_lg(n) != 0) begin
        logic [31:0] hi;
        logic [31:0] span;
        hi   = (n == 2) ? bb[3] : 32'd0;
        span = (32'd1 << win_lg(n)) - 32'd1;
        if (((bb[n] != 0) || (hi != 0)) && ((a[31:0] & ~span) == bb[n]) && (a[63:32] == hi))
          return 6'(1) << n;
      end
    end
    return 6'd0;
  endfunction

  function automatic logic [31:0] mk_addr(input logic [7:0] b, input logic [4:0] d,
                                          input logic [2:0] f, input logic [9:0] dw);
    return {4'h3, b, d, f, dw, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 0; cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_we = 0; cfg_addr = a;
    @(negedge clk);
    cfg_req = 0;
    d = cfg_rdata;
  endtask

  task automatic bar_wr(input int n, input logic [31:0] d);
    cfg_wr(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'(4 + n)), d);
    bb[n] = win_store(n, d);
  endtask

  task automatic hit_probe(input logic [63:0] a, input string req);
    @(negedge clk);
    mem_addr = a;
    #1;
    chk(bar_hit == ref_hit(a), req, {58'd0, bar_hit}, {58'd0, ref_hit(a)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2;
    void'($urandom(32'd20240611));
    for (int n = 0; n < 6; n++) bb[n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk(cfg_rdata == 0, "R1 rdata", cfg_rdata, 0);
    chk(mem_enable == 0, "R1 mem_enable", mem_enable, 0);
    chk(bar_hit == 0, "R1 bar_hit", bar_hit, 0);
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1), r);
    chk(r == 32'h0010_0000, "R1 cmd/status", r, 32'h0010_0000);

    // R4 identity, R5 registered read
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd0), r);
    chk(r == {DID, VID}, "R4/R5 id dword", r, {DID, VID});
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd2), r);
    chk(r == {CLS, REV}, "R4 class dword", r, {CLS, REV});
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd3), r);
    chk(r == 0, "R4 header type single function", r, 0);
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd13), r);
    chk(r == {24'd0, CAPP}, "R4 cap pointer", r, {24'd0, CAPP});
    cfg_wr(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd0), 32'h1234_5678);
    cfg_wr(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd2), 32'hDEAD_BEEF);
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd0), r);
    chk(r == {DID, VID}, "R4 id write ignored", r, {DID, VID});
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd2), r);
    chk(r == {CLS, REV}, "R4 class write ignored", r, {CLS, REV});
    // R5 holds value with no new read
    @(negedge clk);
    chk(cfg_rdata == {CLS, REV}, "R5 rdata held", cfg_rdata, {CLS, REV});

    // R2 low bits and top bits ignored
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd0) ^ 32'hC000_0003, r);
    chk(r == {DID, VID}, "R2 ignored address bits", r, {DID, VID});

    // R2/R3 random foreign locations
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b; logic [4:0] d; logic [2:0] f;
      b = 8'($urandom); d = 5'($urandom); f = 3'($urandom % 2);
      if (i % 3 == 0) b = MY_BUS;
      if (i % 3 == 1) d = MY_DEV;
      if ((b == MY_BUS) && (d == MY_DEV) && (f == 0)) f = 3'd1;
      cfg_rd(mk_addr(b, d, f, 10'd0), r);
      chk(r == 32'hFFFF_FFFF, "R2/R3 foreign read", r, 32'hFFFF_FFFF);
    end
    // R3 foreign write no effect
    cfg_wr(mk_addr(MY_BUS, MY_DEV, 3'd1, 10'd1), 32'hFFFF_FFFF);
    cfg_wr(mk_addr(MY_BUS ^ 8'h01, MY_DEV, 3'd0, 10'd4), 32'hFFFF_FFFF);
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1), r);
    chk(r == 32'h0010_0000, "R3 foreign write cmd", r, 32'h0010_0000);
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd4), r);
    chk(r == 0, "R3 foreign write bar", r, 0);

    // R6/R7 sizing with all ones
    for (int n = 0; n < 6; n++) begin
      logic [31:0] sz;
      bar_wr(n, 32'hFFFF_FFFF);
      cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'(4 + n)), r);
      chk(r == win_read(n), (win_lg(n) == 0 && n != 3) ? "R7 unused bar" : "R6 sizing readback",
          r, win_read(n));
      if (win_lg(n) != 0) begin
        sz = ~(r & 32'hFFFF_FFF0) + 32'd1;
        chk(sz == (32'd1 << win_lg(n)), "R6 derived size", sz, 32'd1 << win_lg(n));
      end
    end
    chk(bb[3] == 32'hFFFF_FFFF, "R7 upper half stores all", bb[3], 32'hFFFF_FFFF);

    // R8 alignment with random bases
    for (int i = 0; i < 12; i++) begin
      int n;
      n = (i % 3) * 2;
      bar_wr(n, $urandom);
      cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'(4 + n)), r);
      chk(r == win_read(n), "R8 aligned base", r, win_read(n));
    end

    // R9 command
    cfg_wr(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1), 32'h0000_FFFF);
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1), r);
    chk(r[15:0] == 16'h0006, "R9 cmd writable bits", r[15:0], 16'h0006);
    chk(mem_enable == 1, "R9 mem_enable on", mem_enable, 1);
    cfg_wr(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1), 32'h0000_0001);
    @(negedge clk);
    chk(mem_enable == 0, "R9 mem_enable off", mem_enable, 0);

    // R10 status events and W1C
    @(negedge clk); stat_evt = 5'b10101;
    @(negedge clk); stat_evt = 0;
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1), r);
    chk(r[31:16] == 16'hA810, "R10 events set", r[31:16], 16'hA810);
    cfg_wr(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1), 32'h0000_0000);
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1), r);
    chk(r[31:16] == 16'hA810, "R10 zero write keeps", r[31:16], 16'hA810);
    cfg_wr(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1), 32'h2010_0000);
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1), r);
    chk(r[31:16] == 16'h8810, "R10 one clears one bit", r[31:16], 16'h8810);
    // set wins over clear in same cycle
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_addr = mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1);
    cfg_wdata = 32'hF800_0000; stat_evt = 5'b00001;
    @(negedge clk);
    cfg_req = 0; cfg_we = 0; stat_evt = 0;
    cfg_rd(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1), r2);
    chk(r2[31:16] == 16'h0810, "R10 set beats clear", r2[31:16], 16'h0810);

    // R11 hit gated while memory disabled
    men_exp = 0;
    hit_probe({bb[3], bb[2]}, "R11 disabled no hit");

    cfg_wr(mk_addr(MY_BUS, MY_DEV, 3'd0, 10'd1), 32'h0000_0002);
    men_exp = 1;

    // R11 random windows and addresses
    for (int k = 0; k < 20; k++) begin
      bar_wr(0, ($urandom % 4 == 0) ? 32'd0 : $urandom);
      bar_wr(2, $urandom);
      bar_wr(3, ($urandom % 2) ? 32'd0 : $urandom);
      bar_wr(4, ($urandom % 4 == 0) ? 32'd0 : $urandom);
      for (int i = 0; i < 15; i++) begin
        logic [63:0] a;
        int n;
        n = ($urandom % 3) * 2;
        case ($urandom % 3)
          0: a = {$urandom, $urandom};
          default: a = {(n == 2) ? bb[3] : 32'd0,
                        bb[n] + ($urandom % (32'd2 << win_lg(n)))};
        endcase
        hit_probe(a, "R11 random hit");
      end
    end

    // R11 zero base never hits
    bar_wr(0, 32'd0); bar_wr(4, 32'd0);
    hit_probe(64'h0000_0000_0000_0010, "R11 zero base");

    // R12 overlap: lowest index wins
    bar_wr(0, 32'h4000_0000);
    bar_wr(4, 32'h4000_0000);
    @(negedge clk); mem_addr = 64'h0000_0000_4000_0010; #1;
    chk(bar_hit == 6'b000001, "R12 overlap priority", bar_hit, 6'b000001);
    @(negedge clk); mem_addr = 64'h0000_0000_4000_0200; #1;
    chk(bar_hit == 6'b000001, "R12 outer window only", bar_hit, 6'b000001);
    bar_wr(0, 32'h5000_0000);
    @(negedge clk); mem_addr = 64'h0000_0000_4000_0010; #1;
    chk(bar_hit == 6'b010000, "R12 BAR4 alone", bar_hit, 6'b010000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule